// File: doc/BRIEF.md
# Floating-Point Last-Instruction Capture Unit

This block keeps the architectural record of the most recent non-control floating-point instruction so that an exception handler or a state-save sequence can find out what was executing. For each retired instruction a retire interface presents its class, the address of its first byte (which is the first prefix byte when prefixes are present), its first two opcode bytes after the prefixes, its memory operand address if it has one, and whether it raised an unmasked exception. Non-control instructions update the record. Control-class instructions (initialize, clear exceptions, control word load or store, status word store, environment load or store, state save or restore, wait) leave it untouched.

Three registers hold the record: an instruction pointer, a data pointer and an 11-bit compacted opcode. A sticky flag holds the exception status of the last captured instruction. An initialize or save event clears the record. A restore port reloads it in a single cycle. A compatibility-mode input decides whether the opcode readout is always valid or is valid only when the last captured instruction faulted.

Top module: `fp_lastop_rec`

## Requirements
- R1: After reset, `ip_o`, `dp_o` and `op_o` are zero, and `op_valid_o` is low while `compat_i` is low.
- R2: A non-control retire (`ret_valid_i`=1, `ret_ctrl_i`=0) sets `ip_o` to {`ret_ip_sel_i`, `ret_ip_off_i`}. Bits 47:32 hold the selector and bits 31:0 hold the offset. The new value is visible in the cycle after the clock edge.
- R3: A non-control retire stores the opcode as {`ret_op0_i`[2:0], `ret_op1_i`}, so bits 10:8 come from the first byte and bits 7:0 come from the second byte. Bits 7:3 of the first byte have no effect.
- R4: A non-control retire with `ret_mem_i`=1 sets `dp_o` to {`ret_dp_sel_i`, `ret_dp_off_i`}, using the same field layout as R2. With `ret_mem_i`=0 it sets `dp_o` to zero.
- R5: A control retire (`ret_ctrl_i`=1) changes none of the instruction pointer, the data pointer, the opcode or the exception flag.
- R6: `clr_i` (initialize or save event) zeroes both pointers, the opcode and the exception flag. It takes priority over a retire in the same cycle.
- R7: `ld_i` loads `ld_ip_i`, `ld_dp_i`, `ld_op_i` and `ld_exc_i` in one cycle. It takes priority over both `clr_i` and a retire in the same cycle.
- R8: While `compat_i` is high, `op_valid_o` is high and `op_o` shows the stored opcode.
- R9: While `compat_i` is low, `op_valid_o` equals the exception flag, and `op_o` is zero whenever the flag is clear.
- R10: The exception flag takes the value of `ret_exc_i` from the last non-control retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_ctrl_i | input | 1 | The retiring instruction is control class |
| ret_ip_off_i | input | 32 | Offset of the instruction's first byte |
| ret_ip_sel_i | input | 16 | Segment selector of the instruction address |
| ret_op0_i | input | 8 | First opcode byte after prefixes |
| ret_op1_i | input | 8 | Second opcode byte |
| ret_mem_i | input | 1 | The instruction has a memory operand |
| ret_dp_off_i | input | 32 | Offset of the memory operand |
| ret_dp_sel_i | input | 16 | Segment selector of the memory operand |
| ret_exc_i | input | 1 | The instruction raised an unmasked exception |
| clr_i | input | 1 | Initialize or save event |
| ld_i | input | 1 | Restore strobe |
| ld_ip_i | input | 48 | Instruction pointer to restore |
| ld_dp_i | input | 48 | Data pointer to restore |
| ld_op_i | input | 11 | Compacted opcode to restore |
| ld_exc_i | input | 1 | Exception flag to restore |
| compat_i | input | 1 | Compatibility mode for opcode reporting |
| ip_o | output | 48 | Stored instruction pointer |
| dp_o | output | 48 | Stored data pointer |
| op_o | output | 11 | Opcode readout |
| op_valid_o | output | 1 | Opcode readout is valid |

## Verification
Restore, clear and a retire can all arrive in the same cycle. The bench drives all eight on/off combinations of the three strobes on top of a record primed with known values. It then checks that the pointers, opcode and flag match restore-over-clear-over-retire precedence, reading the flag through `op_valid_o` with compatibility off and the raw opcode with it on. A separate sweep crosses control class, memory operand, exception and compatibility mode. A full sweep of the first opcode byte shows that the five upper bits are discarded.

// File: rtl/fp_lastop_pkg.sv
package fp_lastop_pkg;
  parameter int unsigned OFF_W   = 32;
  parameter int unsigned SEL_W   = 16;
  parameter int unsigned OP_LO_W = 3;
  localparam int unsigned PTR_W  = OFF_W + SEL_W;
  localparam int unsigned OP_W   = OP_LO_W + 8;
endpackage

// File: rtl/fp_rec_reg.sv
// Record register: restore > clear > capture
module fp_rec_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] cap_val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (ld_i)   q_o <= ld_val_i;
    else if (clr_i)  q_o <= '0;
    else if (cap_i)  q_o <= cap_val_i;
  end
endmodule

// File: rtl/fp_op_pack.sv
// Keeps only the variable low bits of byte 0; the upper bits are a fixed escape pattern
module fp_op_pack #(
  parameter int unsigned LO_W = 3
) (
  input  logic [7:0]      op0_i,
  input  logic [7:0]      op1_i,
  output logic [LO_W+7:0] op_o
);
  logic unused_hi;
  assign unused_hi = ^op0_i[7:LO_W];
  assign op_o = {op0_i[LO_W-1:0], op1_i};
endmodule

// File: rtl/fp_op_report.sv
module fp_op_report #(
  parameter int unsigned W = 11
) (
  input  logic         compat_i,
  input  logic         exc_i,
  input  logic [W-1:0] op_i,
  output logic [W-1:0] op_o,
  output logic         op_valid_o
);
  always_comb begin
    op_valid_o = compat_i | exc_i;
    op_o       = op_valid_o ? op_i : '0;
  end
endmodule

// File: rtl/fp_lastop_rec.sv
module fp_lastop_rec
  import fp_lastop_pkg::*;
#(
  parameter int unsigned P_OFF_W   = OFF_W,
  parameter int unsigned P_SEL_W   = SEL_W,
  parameter int unsigned P_OP_LO_W = OP_LO_W,
  localparam int unsigned P_PTR_W  = P_OFF_W + P_SEL_W,
  localparam int unsigned P_OP_W   = P_OP_LO_W + 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ret_valid_i,
  input  logic               ret_ctrl_i,
  input  logic [P_OFF_W-1:0] ret_ip_off_i,
  input  logic [P_SEL_W-1:0] ret_ip_sel_i,
  input  logic [7:0]         ret_op0_i,
  input  logic [7:0]         ret_op1_i,
  input  logic               ret_mem_i,
  input  logic [P_OFF_W-1:0] ret_dp_off_i,
  input  logic [P_SEL_W-1:0] ret_dp_sel_i,
  input  logic               ret_exc_i,
  input  logic               clr_i,
  input  logic               ld_i,
  input  logic [P_PTR_W-1:0] ld_ip_i,
  input  logic [P_PTR_W-1:0] ld_dp_i,
  input  logic [P_OP_W-1:0]  ld_op_i,
  input  logic               ld_exc_i,
  input  logic               compat_i,
  output logic [P_PTR_W-1:0] ip_o,
  output logic [P_PTR_W-1:0] dp_o,
  output logic [P_OP_W-1:0]  op_o,
  output logic               op_valid_o
);
  logic               cap;
  logic [P_PTR_W-1:0] ip_new, dp_new;
  logic [P_OP_W-1:0]  op_new, op_q;
  logic               exc_q;

  assign cap    = ret_valid_i & ~ret_ctrl_i;
  assign ip_new = {ret_ip_sel_i, ret_ip_off_i};
  assign dp_new = ret_mem_i ? {ret_dp_sel_i, ret_dp_off_i} : '0;

  fp_op_pack #(.LO_W(P_OP_LO_W)) u_pack (
    .op0_i(ret_op0_i), .op1_i(ret_op1_i), .op_o(op_new)
  );

  fp_rec_reg #(.W(P_PTR_W)) u_ip (
    .clk_i, .rst_ni, .ld_i, .ld_val_i(ld_ip_i), .clr_i,
    .cap_i(cap), .cap_val_i(ip_new), .q_o(ip_o)
  );
  fp_rec_reg #(.W(P_PTR_W)) u_dp (
    .clk_i, .rst_ni, .ld_i, .ld_val_i(ld_dp_i), .clr_i,
    .cap_i(cap), .cap_val_i(dp_new), .q_o(dp_o)
  );
  fp_rec_reg #(.W(P_OP_W)) u_op (
    .clk_i, .rst_ni, .ld_i, .ld_val_i(ld_op_i), .clr_i,
    .cap_i(cap), .cap_val_i(op_new), .q_o(op_q)
  );
  fp_rec_reg #(.W(1)) u_exc (
    .clk_i, .rst_ni, .ld_i, .ld_val_i(ld_exc_i), .clr_i,
    .cap_i(cap), .cap_val_i(ret_exc_i), .q_o(exc_q)
  );

  fp_op_report #(.W(P_OP_W)) u_rep (
    .compat_i, .exc_i(exc_q), .op_i(op_q), .op_o, .op_valid_o
  );

  AST_IP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && !ld_i && !clr_i) |=> ip_o == $past({ret_ip_sel_i, ret_ip_off_i})); // R2
  AST_DP_NOMEM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && !ret_mem_i && !ld_i && !clr_i) |=> dp_o == '0); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_ctrl_i && !ld_i && !clr_i) |=>
      ($stable(ip_o) && $stable(dp_o) && $stable(op_q) && $stable(exc_q))); // R5
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ld_i) |=> (ip_o == '0 && dp_o == '0 && op_q == '0 && !exc_q)); // R6
  AST_LD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (ip_o == $past(ld_ip_i) && dp_o == $past(ld_dp_i) &&
              op_q == $past(ld_op_i) && exc_q == $past(ld_exc_i))); // R7
  AST_COMPAT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compat_i |-> (op_valid_o && op_o == op_q)); // R8
  AST_EXC_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && !ld_i && !clr_i) |=> exc_q == $past(ret_exc_i)); // R10
endmodule

// File: tb/sim_fp_lastop_rec.sv
module sim_fp_lastop_rec;
  localparam int CLK_T = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ret_valid_i = 0, ret_ctrl_i = 0, ret_mem_i = 0, ret_exc_i = 0;
  logic [31:0] ret_ip_off_i = 0, ret_dp_off_i = 0;
  logic [15:0] ret_ip_sel_i = 0, ret_dp_sel_i = 0;
  logic [7:0]  ret_op0_i = 0, ret_op1_i = 0;
  logic        clr_i = 0, ld_i = 0, ld_exc_i = 0, compat_i = 0;
  logic [47:0] ld_ip_i = 0, ld_dp_i = 0, ip_o, dp_o;
  logic [10:0] ld_op_i = 0, op_o;
  logic        op_valid_o;

  int n_run = 0, n_fail = 0;
  logic [47:0] e_ip = 0, e_dp = 0;
  logic [10:0] e_op = 0;
  logic        e_exc = 0;

  always #(CLK_T/2) clk_i = ~clk_i;

  fp_lastop_rec u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; expected model follows the requirement precedence
  task automatic step(bit ld, bit clr, bit rv, bit ctrl, bit mem, bit exc,
                      logic [47:0] ip, logic [47:0] dp, logic [7:0] b0, logic [7:0] b1,
                      logic [47:0] lip, logic [47:0] ldp, logic [10:0] lop, bit lexc);
    ld_i = ld; clr_i = clr; ret_valid_i = rv; ret_ctrl_i = ctrl; ret_mem_i = mem;
    ret_exc_i = exc; {ret_ip_sel_i, ret_ip_off_i} = ip; {ret_dp_sel_i, ret_dp_off_i} = dp;
    ret_op0_i = b0; ret_op1_i = b1; ld_ip_i = lip; ld_dp_i = ldp; ld_op_i = lop; ld_exc_i = lexc;
    @(posedge clk_i); #1;
    ld_i = 0; clr_i = 0; ret_valid_i = 0;
    if (ld) begin e_ip = lip; e_dp = ldp; e_op = lop; e_exc = lexc; end
    else if (clr) begin e_ip = 0; e_dp = 0; e_op = 0; e_exc = 0; end
    else if (rv && !ctrl) begin
      e_ip = ip; e_dp = mem ? dp : 48'h0; e_op = {b0 % 8, b1}; e_exc = exc;
    end
  endtask

  task automatic check_all(string req);
    chk({req, " ip"}, 64'(ip_o), 64'(e_ip));
    chk({req, " dp"}, 64'(dp_o), 64'(e_dp));
    chk({req, " valid"}, 64'(op_valid_o), 64'(compat_i | e_exc));
    chk({req, " op"}, 64'(op_o), (compat_i | e_exc) ? 64'(e_op) : 64'h0);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: reset state
    chk("R1 ip", 64'(ip_o), 0); chk("R1 dp", 64'(dp_o), 0);
    chk("R1 op", 64'(op_o), 0); chk("R1 valid", 64'(op_valid_o), 0);

    // Cross sweep: class x mem x exc x compat (R2 R4 R5 R8 R9 R10)
    for (int i = 0; i < 16; i++) begin
      logic [47:0] ipv, dpv;
      ipv = {16'h1000 + 16'(i), 32'hA000_0000 + 32'(i * 273)};
      dpv = {16'h2000 + 16'(i), 32'hB000_0000 + 32'(i * 4099)};
      compat_i = i[3];
      step(0, 0, 1, 0, 1, 1, 48'h0ABC_1234_5678, 48'h0DEF_8765_4321, 8'hDD, 8'h5A,
           0, 0, 0, 0);
      step(0, 0, 1, i[0], i[1], i[2], ipv, dpv, 8'hD8 + 8'(i), 8'(i * 17), 0, 0, 0, 0);
      if (i[0]) check_all("R5 ctrl hold");
      else check_all(i[1] ? "R2 R4 mem R10" : "R2 R4 nomem R10");
      check_all(i[3] ? "R8 compat" : "R9 no compat");
    end

    // R3: every first-byte value; upper bits must be dropped
    compat_i = 1;
    for (int b = 0; b < 256; b++) begin
      step(0, 0, 1, 0, 0, 0, 48'(b), 0, 8'(b), 8'((b * 37 + 11) % 256), 0, 0, 0, 0);
      chk("R3 op", 64'(op_o), 64'({3'(b % 8), 8'((b * 37 + 11) % 256)}));
    end

    // R6 R7: precedence of restore, clear and retire
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 2; c++) begin
        compat_i = 1'(c);
        step(0, 0, 1, 0, 1, 1, 48'h1111_2222_3333, 48'h4444_5555_6666, 8'hD9, 8'hC1,
             0, 0, 0, 0);
        step(m[2], m[1], m[0], 0, 1, 1, 48'h7777_8888_9999, 48'hAAAA_BBBB_CCCC,
             8'hDE, 8'h3C, 48'h0123_4567_89AB, 48'hFEDC_BA98_7654, 11'h5A5, m[0]);
        check_all(m[2] ? "R7 restore wins" : (m[1] ? "R6 clear wins" : "R6 R7 none"));
      end
    end

    // R9 R6: clear after a faulting instruction drops validity
    compat_i = 0;
    step(0, 0, 1, 0, 0, 1, 48'h5, 0, 8'hDF, 8'hE0, 0, 0, 0, 0);
    chk("R9 valid set", 64'(op_valid_o), 1);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 R9 valid cleared", 64'(op_valid_o), 0);
    chk("R6 R9 op zero", 64'(op_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule